// File: doc/BRIEF.md
# Checksummed Configuration Image Builder

This block assembles a configuration image in a small on-chip word memory after a single start pulse. It first copies every word of a template, read from an external template ROM one address per clock, into the image. It then patches a MAC address and a device identifier into fixed word slots. Finally it sums the words that precede a designated checksum slot and writes a checksum word into that slot, so that all words up to and including the slot add to a fixed target value, modulo 2^16.

Each image write is visible on a write port. A separate asynchronous read port lets a checker dump the finished image. A one-cycle done pulse marks the end of the build.

The controller is a state machine with six states, reached in this order:

- `ST_IDLE`: waits for `start`.
- `ST_COPY`: writes template word `idx` to image word `idx`, one per clock.
- `ST_PATCH`: five writes, covering the three MAC words and the two device-ID words.
- `ST_SUM`: reads one image word per clock into the accumulator and writes nothing.
- `ST_CSUM`: writes the checksum word.
- `ST_DONE`: raises `done` for one cycle, then returns to idle.

Transitions are IDLE→COPY on `start`, COPY→PATCH after the last word, PATCH→SUM after the fifth patch, SUM→CSUM after the word just below the checksum slot, CSUM→DONE, and DONE→IDLE.

Top module: `cfg_image_builder`

## Requirements
- R1: Every image word that is not patched and is not the checksum slot equals the template word at the same address after a build.
- R2: Image words 0, 1 and 2 hold the MAC address. Word i has MAC byte 2i in bits [7:0] and byte 2i+1 in bits [15:8]. MAC byte k is `mac_addr[8k+7:8k]`.
- R3: Image words 11 and 13 both equal `dev_id`.
- R4: The checksum slot (index CSUM_IDX) holds (TARGET − sum of words 0..CSUM_IDX−1) mod 2^16. As a result, words 0..CSUM_IDX add to TARGET modulo 2^16.
- R5: `done` is high for exactly one cycle. It rises DEPTH + 5 + CSUM_IDX + 1 rising edges after the edge that samples `start`.
- R6: A `start` pulse that arrives while a build is in progress is ignored. There is no restart, no extra done pulse, and the image is unaffected.
- R7: A build makes exactly DEPTH + 5 + 1 image writes. The last write goes to CSUM_IDX, and no write occurs while sums are accumulated.
- R8: After reset, `done` and `img_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a build (ignored while busy) |
| mac_addr | input | 48 | MAC address, byte k at bits [8k+7:8k] |
| dev_id | input | 16 | Device identifier |
| tpl_addr | output | AW | Template ROM address |
| tpl_data | input | WIDTH | Template ROM data (combinational read) |
| img_we | output | 1 | Image write strobe |
| img_addr | output | AW | Image write address |
| img_wdata | output | WIDTH | Image write data |
| rd_addr | input | AW | Image dump read address |
| rd_data | output | WIDTH | Image dump read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DEPTH=16 and CSUM_IDX=15, which keeps each build to 37 cycles. At that size, a full dump and compare of every image word is cheap on every run. This allows a sweep over many template seeds, plus MAC and device-ID values that include all-zero and all-one patterns. Checksum wrap-around and exact done latency are therefore checked on many distinct images. A second set of runs injects stray start pulses during the copy and sum phases.

// File: rtl/cfg_image_pkg.sv
package cfg_image_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COPY  = 3'd1,
        ST_PATCH = 3'd2,
        ST_SUM   = 3'd3,
        ST_CSUM  = 3'd4,
        ST_DONE  = 3'd5
    } build_state_t;

    localparam int NPATCH  = 5;
    localparam int PSEL_W  = 3;
endpackage

// File: rtl/cfg_patch_sel.sv
module cfg_patch_sel
    import cfg_image_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int AW         = 6,
    parameter int DEV_SLOT_A = 11,
    parameter int DEV_SLOT_B = 13
) (
    input  logic [PSEL_W-1:0] sel,
    input  logic [47:0]       mac_addr,
    input  logic [15:0]       dev_id,
    output logic [AW-1:0]     p_addr,
    output logic [WIDTH-1:0]  p_data
);
    always_comb begin
        p_addr = '0;
        p_data = '0;
        unique case (sel)
            3'd0: begin p_addr = AW'(0); p_data = WIDTH'(mac_addr[15:0]);  end
            3'd1: begin p_addr = AW'(1); p_data = WIDTH'(mac_addr[31:16]); end
            3'd2: begin p_addr = AW'(2); p_data = WIDTH'(mac_addr[47:32]); end
            3'd3: begin p_addr = AW'(DEV_SLOT_A); p_data = WIDTH'(dev_id); end
            3'd4: begin p_addr = AW'(DEV_SLOT_B); p_data = WIDTH'(dev_id); end
            default: begin p_addr = '0; p_data = '0; end
        endcase
    end
endmodule

// File: rtl/cfg_csum_acc.sv
module cfg_csum_acc #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (en)  sum <= sum + din;
    end
endmodule

// File: rtl/cfg_image_builder.sv
module cfg_image_builder
    import cfg_image_pkg::*;
#(
    parameter int           WIDTH    = 16,
    parameter int           DEPTH    = 64,
    parameter int           CSUM_IDX = 63,
    parameter logic [15:0]  TARGET   = 16'hBABA,
    localparam int          AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [47:0]      mac_addr,
    input  logic [15:0]      dev_id,
    output logic [AW-1:0]    tpl_addr,
    input  logic [WIDTH-1:0] tpl_data,
    output logic             img_we,
    output logic [AW-1:0]    img_addr,
    output logic [WIDTH-1:0] img_wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             done
);
    build_state_t state, state_nx;
    logic [AW-1:0]     idx;
    logic [PSEL_W-1:0] pidx;
    logic [WIDTH-1:0]  image [DEPTH];
    logic [AW-1:0]     p_addr;
    logic [WIDTH-1:0]  p_data;
    logic [WIDTH-1:0]  acc_sum;

    cfg_patch_sel #(.WIDTH(WIDTH), .AW(AW)) u_patch (
        .sel(pidx), .mac_addr(mac_addr), .dev_id(dev_id),
        .p_addr(p_addr), .p_data(p_data)
    );

    cfg_csum_acc #(.WIDTH(WIDTH)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_IDLE), .en(state == ST_SUM),
        .din(image[idx]), .sum(acc_sum)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_COPY;
            ST_COPY:  if (idx == AW'(DEPTH - 1)) state_nx = ST_PATCH;
            ST_PATCH: if (pidx == PSEL_W'(NPATCH - 1)) state_nx = ST_SUM;
            ST_SUM:   if (idx == AW'(CSUM_IDX - 1)) state_nx = ST_CSUM;
            ST_CSUM:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // per-phase counters restart on each state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            pidx <= '0;
        end else if (state_nx != state) begin
            idx  <= '0;
            pidx <= '0;
        end else begin
            idx  <= idx + 1'b1;
            pidx <= (state == ST_PATCH) ? pidx + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        img_we    = 1'b0;
        img_addr  = idx;
        img_wdata = tpl_data;
        done      = 1'b0;
        unique case (state)
            ST_COPY:  img_we = 1'b1;
            ST_PATCH: begin
                img_we    = 1'b1;
                img_addr  = p_addr;
                img_wdata = p_data;
            end
            ST_CSUM: begin
                img_we    = 1'b1;
                img_addr  = AW'(CSUM_IDX);
                img_wdata = WIDTH'(TARGET) - acc_sum;
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign tpl_addr = idx;

    always_ff @(posedge clk) begin
        if (img_we) image[img_addr] <= img_wdata;
    end

    assign rd_data = image[rd_addr];

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_csum_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(img_we) && $past(img_addr) == AW'(CSUM_IDX)));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_DONE) |=> !(state == ST_COPY && idx == '0));

    assert_no_write_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUM) |-> !img_we);

    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUM) |-> ($past(state) == ST_PATCH || $past(state) == ST_SUM));

    always_comb begin
        if (rst_n) begin
            assert_done_idle_R8: assert (!(done && img_we));
        end
    end
endmodule

// File: tb/cfg_image_builder_bench.sv
module cfg_image_builder_bench;
    localparam int DEPTH = 16;
    localparam int CSUM  = 15;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [15:0] TGT = 16'hBABA;
    localparam int LAT   = DEPTH + 5 + CSUM + 1;
    localparam int NWR   = DEPTH + 5 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [47:0] mac = '0;
    logic [15:0] dev = '0;
    logic [AW-1:0] tpl_addr, img_addr, rd_addr;
    logic [15:0] tpl_data, img_wdata, rd_data;
    logic img_we, done;
    logic [15:0] seed = '0;
    int checks = 0, failures = 0;
    int wr_cnt = 0;
    logic [AW-1:0] last_addr;
    logic [15:0] last_data;
    logic [15:0] expv [DEPTH];

    always #4 clk = ~clk;

    function automatic logic [15:0] tpl_fn(input logic [AW-1:0] a, input logic [15:0] s);
        return (16'(a) * 16'h9E37) ^ s ^ {s[7:0], s[15:8]};
    endfunction

    assign tpl_data = tpl_fn(tpl_addr, seed);

    cfg_image_builder #(.WIDTH(16), .DEPTH(DEPTH), .CSUM_IDX(CSUM), .TARGET(TGT))
    u_cfg_image_builder (
        .clk(clk), .rst_n(rst_n), .start(start), .mac_addr(mac), .dev_id(dev),
        .tpl_addr(tpl_addr), .tpl_data(tpl_data), .img_we(img_we),
        .img_addr(img_addr), .img_wdata(img_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done)
    );

    always @(negedge clk) begin
        if (img_we) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= img_addr;
            last_data <= img_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] s, input logic [47:0] m, input logic [15:0] d,
                       input bit stray);
        int n;
        int dones;
        logic [15:0] sm;
        bit ok1, ok2, ok3;
        seed = s; mac = m; dev = d;
        for (int i = 0; i < DEPTH; i++) expv[i] = tpl_fn(AW'(i), s);
        expv[0] = m[15:0]; expv[1] = m[31:16]; expv[2] = m[47:32];
        expv[11] = d; expv[13] = d;
        sm = '0;
        for (int i = 0; i < CSUM; i++) sm = sm + expv[i];
        expv[CSUM] = TGT - sm;
        @(negedge clk);
        wr_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        dones = 0;
        while (n < LAT + 10) begin
            @(negedge clk);
            n++;
            if (stray && (n == 3 || n == 30)) start = 1'b1;
            else start = 1'b0;
            if (done) begin
                dones++;
                if (dones == 1) check(n == LAT, "R5 latency", n, LAT);
            end
        end
        start = 1'b0;
        check(dones == 1, stray ? "R6 single done" : "R5 single pulse", dones, 1);
        check(wr_cnt == NWR, "R7 write count", wr_cnt, NWR);
        check(last_addr == AW'(CSUM) && last_data == expv[CSUM], "R7 last write",
              {last_addr, last_data}, {AW'(CSUM), expv[CSUM]});
        ok1 = 1; ok2 = 1; ok3 = 1;
        sm = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = AW'(i);
            #1;
            if (i <= CSUM) sm = sm + rd_data;
            if (rd_data !== expv[i]) begin
                if (i < 3) ok2 = 0;
                else if (i == 11 || i == 13) ok3 = 0;
                else if (i != CSUM) ok1 = 0;
                $display("FAIL R1-image word %0d actual=%0h expected=%0h", i, rd_data, expv[i]);
                failures++;
            end
        end
        check(ok1, stray ? "R6 template words" : "R1 template words", ok1, 1);
        check(ok2, "R2 mac words", ok2, 1);
        check(ok3, "R3 devid words", ok3, 1);
        check(sm == TGT, "R4 image sum", sm, TGT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && img_we == 1'b0, "R8 reset outputs", {done, img_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && img_we == 1'b0, "R8 idle outputs", {done, img_we}, 0);
        run(16'h0000, 48'h0000_0000_0000, 16'h0000, 0);
        run(16'hFFFF, 48'hFFFF_FFFF_FFFF, 16'hFFFF, 0);
        run(16'h1234, 48'h5544_3322_1100, 16'h100E, 0);
        for (int k = 0; k < 24; k++)
            run(16'(k * 16'h3B1D + 7), {16'(k * 5 + 1), 16'(k * 16'h0F0F), 16'(~k)},
                16'(k * 16'h1111), 0);
        run(16'hA5A5, 48'h0102_0304_0506, 16'h8086, 1);
        run(16'h5A5A, 48'hFEDC_BA98_7654, 16'h0001, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule